// File: doc/BRIEF.md
# Two-Sided Doorbell Mailbox Register File

This block is a small register file shared by two agents on the same clock: a host and a management controller. Each agent has its own plain synchronous register port. Either agent can fill a bank of byte-wide data registers. A per-register update flag tells the other side which bytes changed. A doorbell bit in each side's control register raises a pending flag on the far side. Each side has a level interrupt. It is raised either by an unmasked pending doorbell or by an update flag whose interrupt enable is set.

The data-register count is the parameter `NUM_REGS`, either 16 or 32. Every register occupies a 32-bit slot on a 4-byte stride. Only the low byte of a slot holds state, and the upper 24 bits always read as zero. All byte offsets are derived from `NUM_REGS` (N):
- Data registers start at 0.
- The update-flag words start at 4N, with eight flags per word.
- The management control register sits at 4N+N/2, and the host control register at 4N+N/2+4.
- The management enable words start at 5N, and the host enable words at 5N+N/2.

For N=16 these offsets are 0x40, 0x48, 0x4C, 0x50 and 0x58.

Neither port has back-pressure: a write is taken on the clock edge where its strobe is high, and a read returns its data one cycle after the read strobe. Both ports decode the same map. The update-flag offsets show the caller's own flags, and the control and enable offsets that belong to the other side are unmapped for the caller.

Top module: `mbx_regfile`

## Requirements
- R1: After reset all data, flag, enable and control state is zero, both interrupts are low and both read-data outputs are zero.
- R2: A write from either port to offset 4n stores the low byte in data register n, and both ports read it back one cycle after a read strobe. When both ports write the same data register in one cycle, the management byte is kept.
- R3: Read data bits 31:8 are always zero. A read of an unmapped or misaligned offset (addr[1:0] not 0) returns 0, and a write there changes no state. The other side's control and enable offsets are unmapped.
- R4: A host write to data register n sets management update flag n. A management write sets host update flag n. Flag n is bit n%8 of the word at 4N+4*(n/8), read through the owning side's port.
- R5: Writing 1 to an update-flag bit clears it; writing 0 leaves it unchanged.
- R6: Writing a byte with bit 0 set to a side's own control register sets bit 7 (pending) of the other side's control register. Bit 0 always reads 0.
- R7: Control bit 7 is cleared by writing 1 to it. Control bit 1 (mask) is plain read/write, so writing 0x80 clears pending and mask in one access.
- R8: Each side's enable words are read/write bytes with one bit per data register, accessible only from that side.
- R9: A side's interrupt is a registered level: it equals (pending AND NOT mask) OR any(flag AND enable) of the previous cycle's state.
- R10: When a set event (data write or doorbell) and a write-one-to-clear hit the same bit in one cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgt_addr | input | 8 | Management byte address |
| mgt_wr | input | 1 | Management write strobe |
| mgt_wdata | input | 8 | Management write byte |
| mgt_rd | input | 1 | Management read strobe |
| mgt_rdata | output | 32 | Management read data, valid the cycle after mgt_rd |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 32 | Host read data, valid the cycle after host_rd |
| mgt_irq | output | 1 | Management interrupt, active-high level |
| host_irq | output | 1 | Host interrupt, active-high level |

## Verification
The bound checker watches, on every cycle, that a data write lands in the peer's update flag, that flags and pending bits rise only for a matching cause, and that each interrupt follows its unmasked pending bit and its enabled flags with one register of delay. Only the bench scenarios can show the address map itself: readback values, zero upper bytes, unmapped and misaligned accesses being ignored, management priority on a data collision, and the exact bytes seen through each port after write-one-to-clear and set-versus-clear collisions.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_DATA,
    RG_FLAG,
    RG_CTRL,
    RG_EN
  } mbx_region_e;

  localparam int CTRL_PEND_BIT = 7;
  localparam int CTRL_MASK_BIT = 1;
  localparam int CTRL_SEND_BIT = 0;

  // Word (4-byte) indices of each region, derived from the data count.
  function automatic int flag_word(input int n);
    return n;
  endfunction
  function automatic int ctrl_word(input int n, input bit is_host);
    return n + n / 8 + (is_host ? 1 : 0);
  endfunction
  function automatic int en_word(input int n, input bit is_host);
    return (n * 5) / 4 + (is_host ? n / 8 : 0);
  endfunction
endpackage

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int  N       = 16,
  parameter int  ADDR_W  = 8,
  parameter bit  IS_HOST = 1'b0,
  localparam int IDX_W   = $clog2(N),
  localparam int GRP     = N / 8,
  localparam int GIDX_W  = (GRP > 1) ? $clog2(GRP) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr,
  input  logic                  rd,
  output logic [31:0]           rdata,
  input  logic [N-1:0][7:0]     data_q,
  input  logic [N-1:0]          flags,
  input  logic [N-1:0]          enables,
  input  logic [7:0]            ctrl,
  output logic                  data_we,
  output logic [IDX_W-1:0]      data_idx,
  output logic                  flag_we,
  output logic                  ctrl_we,
  output logic                  en_we,
  output logic [GIDX_W-1:0]     gidx
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_DATA_END = WORD_W'(N);
  localparam logic [WORD_W-1:0] W_FLAG     = WORD_W'(flag_word(N));
  localparam logic [WORD_W-1:0] W_CTRL     = WORD_W'(ctrl_word(N, IS_HOST));
  localparam logic [WORD_W-1:0] W_EN       = WORD_W'(en_word(N, IS_HOST));
  localparam logic [WORD_W-1:0] W_GRP      = WORD_W'(GRP);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] flag_off;
  logic [WORD_W-1:0] en_off;
  mbx_region_e       region;
  logic [GRP-1:0][7:0] flag_g;
  logic [GRP-1:0][7:0] en_g;
  logic [7:0]        rbyte;

  assign word     = addr[ADDR_W-1:2];
  assign flag_off = word - W_FLAG;
  assign en_off   = word - W_EN;
  assign flag_g   = flags;
  assign en_g     = enables;

  always_comb begin
    region   = RG_NONE;
    data_idx = '0;
    gidx     = '0;
    if (addr[1:0] == 2'b00) begin
      if (word < W_DATA_END) begin
        region   = RG_DATA;
        data_idx = word[IDX_W-1:0];
      end else if (word >= W_FLAG && flag_off < W_GRP) begin
        region = RG_FLAG;
        gidx   = flag_off[GIDX_W-1:0];
      end else if (word == W_CTRL) begin
        region = RG_CTRL;
      end else if (word >= W_EN && en_off < W_GRP) begin
        region = RG_EN;
        gidx   = en_off[GIDX_W-1:0];
      end
    end
  end

  assign data_we = wr && (region == RG_DATA);
  assign flag_we = wr && (region == RG_FLAG);
  assign ctrl_we = wr && (region == RG_CTRL);
  assign en_we   = wr && (region == RG_EN);

  always_comb begin
    unique case (region)
      RG_DATA: rbyte = data_q[data_idx];
      RG_FLAG: rbyte = flag_g[gidx];
      RG_CTRL: rbyte = ctrl;
      RG_EN:   rbyte = en_g[gidx];
      default: rbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= {24'h000000, rbyte};
    end
  end
endmodule

// File: rtl/mbx_data.sv
module mbx_data #(
  parameter int  N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 m_we,
  input  logic [IDX_W-1:0]     m_idx,
  input  logic [7:0]           m_byte,
  input  logic                 h_we,
  input  logic [IDX_W-1:0]     h_idx,
  input  logic [7:0]           h_byte,
  output logic [N-1:0][7:0]    data_q,
  output logic [N-1:0]         m_hit,
  output logic [N-1:0]         h_hit
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    assign m_hit[i] = m_we && (m_idx == IDX_W'(i));
    assign h_hit[i] = h_we && (h_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[i] <= 8'h00;
      end else if (m_hit[i]) begin
        data_q[i] <= m_byte;
      end else if (h_hit[i]) begin
        data_q[i] <= h_byte;
      end
    end
  end
endmodule

// File: rtl/mbx_side.sv
module mbx_side
  import mbx_pkg::*;
#(
  parameter int  N      = 16,
  localparam int GRP    = N / 8,
  localparam int GIDX_W = (GRP > 1) ? $clog2(GRP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_we,
  input  logic              ctrl_we,
  input  logic              en_we,
  input  logic [GIDX_W-1:0] gidx,
  input  logic [7:0]        wbyte,
  input  logic [N-1:0]      set_vec,
  input  logic              ring_in,
  output logic [N-1:0]      flags,
  output logic [N-1:0]      enables,
  output logic              pend,
  output logic              mask,
  output logic [7:0]        ctrl,
  output logic              ring_out,
  output logic              irq
);
  logic [N-1:0] clr;

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    logic sel;
    assign sel = (gidx == GIDX_W'(g));
    assign clr[g*8 +: 8] = (flag_we && sel) ? wbyte : 8'h00;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        enables[g*8 +: 8] <= 8'h00;
      end else if (en_we && sel) begin
        enables[g*8 +: 8] <= wbyte;
      end
    end
  end

  assign ring_out = ctrl_we && wbyte[CTRL_SEND_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      pend  <= 1'b0;
      mask  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | set_vec;
      pend  <= (pend & ~(ctrl_we && wbyte[CTRL_PEND_BIT])) | ring_in;
      if (ctrl_we) begin
        mask <= wbyte[CTRL_MASK_BIT];
      end
      irq <= (pend && !mask) || (|(flags & enables));
    end
  end

  always_comb begin
    ctrl                = 8'h00;
    ctrl[CTRL_PEND_BIT] = pend;
    ctrl[CTRL_MASK_BIT] = mask;
  end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
  parameter int  NUM_REGS = 16,
  parameter int  ADDR_W   = 8,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int GRP      = NUM_REGS / 8,
  localparam int GIDX_W   = (GRP > 1) ? $clog2(GRP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mgt_addr,
  input  logic              mgt_wr,
  input  logic [7:0]        mgt_wdata,
  input  logic              mgt_rd,
  output logic [31:0]       mgt_rdata,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  input  logic              host_rd,
  output logic [31:0]       host_rdata,
  output logic              mgt_irq,
  output logic              host_irq
);
  logic [NUM_REGS-1:0][7:0] data_q;
  logic [NUM_REGS-1:0]      m_hit, h_hit;
  logic [NUM_REGS-1:0]      m_flags, h_flags, m_en, h_en;
  logic [7:0]               m_ctrl, h_ctrl;
  logic                     m_pend, h_pend, m_mask, h_mask, m_ring, h_ring;
  logic                     m_data_we, h_data_we, m_flag_we, h_flag_we;
  logic                     m_ctrl_we, h_ctrl_we, m_en_we, h_en_we;
  logic [IDX_W-1:0]         m_data_idx, h_data_idx;
  logic [GIDX_W-1:0]        m_gidx, h_gidx;

  mbx_port #(.N(NUM_REGS), .ADDR_W(ADDR_W), .IS_HOST(1'b0)) u_mport (
    .clk(clk), .rst_n(rst_n), .addr(mgt_addr), .wr(mgt_wr), .rd(mgt_rd),
    .rdata(mgt_rdata), .data_q(data_q), .flags(m_flags), .enables(m_en),
    .ctrl(m_ctrl), .data_we(m_data_we), .data_idx(m_data_idx),
    .flag_we(m_flag_we), .ctrl_we(m_ctrl_we), .en_we(m_en_we), .gidx(m_gidx)
  );

  mbx_port #(.N(NUM_REGS), .ADDR_W(ADDR_W), .IS_HOST(1'b1)) u_hport (
    .clk(clk), .rst_n(rst_n), .addr(host_addr), .wr(host_wr), .rd(host_rd),
    .rdata(host_rdata), .data_q(data_q), .flags(h_flags), .enables(h_en),
    .ctrl(h_ctrl), .data_we(h_data_we), .data_idx(h_data_idx),
    .flag_we(h_flag_we), .ctrl_we(h_ctrl_we), .en_we(h_en_we), .gidx(h_gidx)
  );

  mbx_data #(.N(NUM_REGS)) u_data (
    .clk(clk), .rst_n(rst_n),
    .m_we(m_data_we), .m_idx(m_data_idx), .m_byte(mgt_wdata),
    .h_we(h_data_we), .h_idx(h_data_idx), .h_byte(host_wdata),
    .data_q(data_q), .m_hit(m_hit), .h_hit(h_hit)
  );

  // Management-side flags are raised by host data writes, and vice versa.
  mbx_side #(.N(NUM_REGS)) u_mside (
    .clk(clk), .rst_n(rst_n), .flag_we(m_flag_we), .ctrl_we(m_ctrl_we),
    .en_we(m_en_we), .gidx(m_gidx), .wbyte(mgt_wdata), .set_vec(h_hit),
    .ring_in(h_ring), .flags(m_flags), .enables(m_en), .pend(m_pend),
    .mask(m_mask), .ctrl(m_ctrl), .ring_out(m_ring), .irq(mgt_irq)
  );

  mbx_side #(.N(NUM_REGS)) u_hside (
    .clk(clk), .rst_n(rst_n), .flag_we(h_flag_we), .ctrl_we(h_ctrl_we),
    .en_we(h_en_we), .gidx(h_gidx), .wbyte(host_wdata), .set_vec(m_hit),
    .ring_in(m_ring), .flags(h_flags), .enables(h_en), .pend(h_pend),
    .mask(h_mask), .ctrl(h_ctrl), .ring_out(h_ring), .irq(host_irq)
  );
endmodule

// File: rtl/mbx_regfile_chk.sv
module mbx_regfile_chk #(
  parameter int  N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mgt_irq,
  input logic             host_irq,
  input logic             m_pend,
  input logic             m_mask,
  input logic             h_pend,
  input logic             h_mask,
  input logic [N-1:0]     m_flags,
  input logic [N-1:0]     h_flags,
  input logic [N-1:0]     m_en,
  input logic [N-1:0]     h_en,
  input logic             m_ring,
  input logic             h_ring,
  input logic             m_data_we,
  input logic [IDX_W-1:0] m_data_idx,
  input logic             h_data_we,
  input logic [IDX_W-1:0] h_data_idx
);
  p_host_write_flags_mgt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    h_data_we |=> m_flags[$past(h_data_idx)]);
  p_mgt_write_flags_host_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_data_we |=> h_flags[$past(m_data_idx)]);
  p_mflag_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(m_flags & ~$past(m_flags))) |-> $past(h_data_we));
  p_hflag_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(h_flags & ~$past(h_flags))) |-> $past(m_data_we));
  p_ring_to_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_ring |=> h_pend);
  p_ring_to_mgt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    h_ring |=> m_pend);
  p_mpend_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_pend) |-> $past(h_ring));
  p_hpend_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_pend) |-> $past(m_ring));
  p_mirq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_pend && !m_mask) |=> mgt_irq);
  p_mirq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(m_pend && !m_mask) && ((m_flags & m_en) == '0)) |=> !mgt_irq);
  p_hirq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_pend && !h_mask) |=> host_irq);
  p_hirq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(h_pend && !h_mask) && ((h_flags & h_en) == '0)) |=> !host_irq);
endmodule

bind mbx_regfile mbx_regfile_chk #(.N(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mgt_irq(mgt_irq), .host_irq(host_irq),
  .m_pend(m_pend), .m_mask(m_mask), .h_pend(h_pend), .h_mask(h_mask),
  .m_flags(m_flags), .h_flags(h_flags), .m_en(m_en), .h_en(h_en),
  .m_ring(m_ring), .h_ring(h_ring),
  .m_data_we(m_data_we), .m_data_idx(m_data_idx),
  .h_data_we(h_data_we), .h_data_idx(h_data_idx)
);

// File: tb/test_mbx_regfile.sv
module test_mbx_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mgt_addr = '0, host_addr = '0;
  logic        mgt_wr = 1'b0, host_wr = 1'b0, mgt_rd = 1'b0, host_rd = 1'b0;
  logic [7:0]  mgt_wdata = '0, host_wdata = '0;
  logic [31:0] mgt_rdata, host_rdata;
  logic        mgt_irq, host_irq;
  int          checks = 0;
  int          failures = 0;

  always #2.5 clk = ~clk;

  mbx_regfile i_mbx_regfile (
    .clk(clk), .rst_n(rst_n),
    .mgt_addr(mgt_addr), .mgt_wr(mgt_wr), .mgt_wdata(mgt_wdata), .mgt_rd(mgt_rd),
    .mgt_rdata(mgt_rdata),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .mgt_irq(mgt_irq), .host_irq(host_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // One cycle with optional writes on both ports.
  task automatic both_wr(input logic mw, input logic [7:0] ma, input logic [7:0] md,
                         input logic hw, input logic [7:0] ha, input logic [7:0] hd);
    @(negedge clk);
    mgt_wr = mw; mgt_addr = ma; mgt_wdata = md;
    host_wr = hw; host_addr = ha; host_wdata = hd;
    @(negedge clk);
    mgt_wr = 1'b0; host_wr = 1'b0;
  endtask

  task automatic mwr(input logic [7:0] a, input logic [7:0] d);
    both_wr(1'b1, a, d, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic hwr(input logic [7:0] a, input logic [7:0] d);
    both_wr(1'b0, 8'h00, 8'h00, 1'b1, a, d);
  endtask

  task automatic mrd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    mgt_rd = 1'b1; mgt_addr = a;
    @(negedge clk);
    mgt_rd = 1'b0;
    chk(req, mgt_rdata, exp);
  endtask

  task automatic hrd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    chk(req, host_rdata, exp);
  endtask

  task automatic t_reset();
    chk("R1 mgt_irq", {31'b0, mgt_irq}, 32'h0);
    chk("R1 host_irq", {31'b0, host_irq}, 32'h0);
    chk("R1 mgt_rdata", mgt_rdata, 32'h0);
    mrd_chk("R1 mgt ctrl", 8'h48, 32'h0);
    hrd_chk("R1 host ctrl", 8'h4C, 32'h0);
    mrd_chk("R1 data0", 8'h00, 32'h0);
  endtask

  task automatic t_data();
    hwr(8'h0C, 8'hA5);
    mrd_chk("R2 mgt reads host byte", 8'h0C, 32'h000000A5);
    hrd_chk("R2 host reads own byte", 8'h0C, 32'h000000A5);
    mwr(8'h3C, 8'h5C);
    hrd_chk("R2 R3 host reads data15", 8'h3C, 32'h0000005C);
  endtask

  task automatic t_flags();
    mrd_chk("R4 mgt flag word0", 8'h40, 32'h08);
    mrd_chk("R4 mgt flag word1", 8'h44, 32'h00);
    hrd_chk("R4 host flag word1", 8'h44, 32'h80);
    hrd_chk("R4 host flag word0", 8'h40, 32'h00);
    mwr(8'h40, 8'hF7);
    mrd_chk("R5 zero bits no effect", 8'h40, 32'h08);
    mwr(8'h40, 8'h08);
    mrd_chk("R5 one clears", 8'h40, 32'h00);
    hwr(8'h44, 8'h80);
    hrd_chk("R5 host clears", 8'h44, 32'h00);
  endtask

  task automatic t_enable();
    hwr(8'h58, 8'hA5);
    hwr(8'h5C, 8'h3C);
    hrd_chk("R8 host en0", 8'h58, 32'hA5);
    hrd_chk("R8 host en1", 8'h5C, 32'h3C);
    mrd_chk("R8 R3 host en hidden from mgt", 8'h58, 32'h00);
    hwr(8'h58, 8'h00);
    hwr(8'h5C, 8'h00);
    hrd_chk("R8 host en0 cleared", 8'h58, 32'h00);
  endtask

  task automatic t_irq_flags();
    mwr(8'h50, 8'h08);
    mrd_chk("R8 mgt en0", 8'h50, 32'h08);
    hwr(8'h0C, 8'h33);
    chk("R9 irq not yet", {31'b0, mgt_irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq one cycle later", {31'b0, mgt_irq}, 32'h1);
    mwr(8'h40, 8'h08);
    @(negedge clk);
    chk("R9 irq drops after clear", {31'b0, mgt_irq}, 32'h0);
    hwr(8'h0C, 8'h33);
    @(negedge clk);
    chk("R9 irq again", {31'b0, mgt_irq}, 32'h1);
    mwr(8'h50, 8'h00);
    @(negedge clk);
    chk("R9 irq drops when disabled", {31'b0, mgt_irq}, 32'h0);
    mwr(8'h40, 8'h08);
    mrd_chk("R5 flag cleared", 8'h40, 32'h00);
  endtask

  task automatic t_doorbell();
    hwr(8'h4C, 8'h01);
    @(negedge clk);
    chk("R6 R9 mgt irq on doorbell", {31'b0, mgt_irq}, 32'h1);
    mrd_chk("R6 mgt pending", 8'h48, 32'h80);
    hrd_chk("R6 send reads zero", 8'h4C, 32'h00);
    mwr(8'h48, 8'h02);
    mrd_chk("R7 mask set pending kept", 8'h48, 32'h82);
    chk("R9 masked irq low", {31'b0, mgt_irq}, 32'h0);
    mwr(8'h48, 8'h80);
    mrd_chk("R7 0x80 clears both", 8'h48, 32'h00);
    mwr(8'h48, 8'h01);
    @(negedge clk);
    chk("R6 host irq on doorbell", {31'b0, host_irq}, 32'h1);
    hrd_chk("R6 host pending", 8'h4C, 32'h80);
    mrd_chk("R6 sender pending unchanged", 8'h48, 32'h00);
    hwr(8'h4C, 8'h80);
    hrd_chk("R7 host pending cleared", 8'h4C, 32'h00);
    chk("R9 host irq low", {31'b0, host_irq}, 32'h0);
  endtask

  task automatic t_unmapped();
    mwr(8'h60, 8'hFF);
    mrd_chk("R3 unmapped reads zero", 8'h60, 32'h00);
    mwr(8'h0D, 8'h77);
    mrd_chk("R3 misaligned write ignored", 8'h0C, 32'h33);
    hrd_chk("R3 misaligned sets no flag", 8'h40, 32'h00);
    hwr(8'h50, 8'hFF);
    mrd_chk("R3 host write to mgt en ignored", 8'h50, 32'h00);
    hrd_chk("R3 host reads mgt en as zero", 8'h50, 32'h00);
    hwr(8'h48, 8'h01);
    mrd_chk("R3 host write to mgt ctrl ignored", 8'h48, 32'h00);
  endtask

  task automatic t_collide();
    both_wr(1'b1, 8'h14, 8'h11, 1'b1, 8'h14, 8'h22);
    hrd_chk("R2 mgt wins collision", 8'h14, 32'h11);
    mrd_chk("R4 mgt flag5", 8'h40, 32'h20);
    hrd_chk("R4 host flag5", 8'h40, 32'h20);
    both_wr(1'b1, 8'h40, 8'h20, 1'b1, 8'h14, 8'h44);
    mrd_chk("R10 set beats clear flag", 8'h40, 32'h20);
    mrd_chk("R2 data5 updated", 8'h14, 32'h44);
    mwr(8'h40, 8'h20);
    mrd_chk("R5 flag5 cleared", 8'h40, 32'h00);
    both_wr(1'b1, 8'h48, 8'h80, 1'b1, 8'h4C, 8'h01);
    mrd_chk("R10 set beats clear pending", 8'h48, 32'h80);
    mwr(8'h48, 8'h80);
    mrd_chk("R7 pending cleared", 8'h48, 32'h00);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data();
    t_flags();
    t_enable();
    t_irq_flags();
    t_doorbell();
    t_unmapped();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule